// File: doc/BRIEF.md
# Fuse-configured sum-of-products array

This block is the logic core of a small programmable device. A flat configuration vector says which input literals feed each AND term. The block computes, for each output cell, an OR of that cell's product terms. Each cell also gets one separate enable term. Two global terms, one for reset and one for preset, are computed alongside. The cells do not all get the same number of product terms. The middle cells get the most, and the count shrinks by two per step towards both ends of the array.

The caller builds the 22-bit array input from device inputs and feedback. The caller also holds the configuration vector static. Loading that vector is done elsewhere. The block registers every result: the cell sums, the cell enables, the global reset term, the global preset term and the per-cell mode bits. Each result therefore appears one clock after its inputs.

Top module: `pla_array`

## Requirements
- R1: While `rst` is high at a rising clock edge, every registered output (`sum_out`, `oe_out`, `ar_out`, `sp_out`, `mode_out`) becomes zero.
- R2: Outputs are registered. A change on `arr_in` or `fuse_map` shows at the outputs after the next rising edge and not before it.
- R3: Each row has 44 configuration bits. Column 2i stands for array input i in true form, and column 2i+1 for its complement. A bit value of 1 (intact) puts that literal into the AND term. A row with both literals of any one input intact is always 0, so a fully intact row gives 0.
- R4: A row whose bits are all 0 (all blown) holds no literal and evaluates to 1.
- R5: A cell's sum is the OR of its logic rows only. Its enable row never affects the sum.
- R6: `oe_out[k]` is the product term of the first row of cell k.
- R7: Cells 0..9 get 8, 10, 12, 14, 16, 16, 14, 12, 10, 8 logic rows. Each cell's row block is its enable row followed by its logic rows. Cell 0's block starts at bit 44, and the blocks follow one another with no gaps.
- R8: `ar_out` is the product term of the row at bits 0..43.
- R9: `sp_out` is the product term of the row starting at bit 5764.
- R10: `mode_out[2k]` takes bit 5808+2k and `mode_out[2k+1]` takes bit 5809+2k. The map is 5828 bits wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fuse_map | input | 5828 | Static configuration vector, 1 = literal connected |
| arr_in | input | 22 | Array inputs, device inputs and feedback |
| sum_out | output | 10 | Registered per-cell sums of logic terms |
| oe_out | output | 10 | Registered per-cell enable terms |
| ar_out | output | 1 | Registered global reset term |
| sp_out | output | 1 | Registered global preset term |
| mode_out | output | 20 | Registered per-cell mode bit pairs |

## Verification
Some properties are checked on every cycle:
- a row that connects both polarities of any input never produces a 1;
- an empty row always produces a 1;
- a cell with no active logic row never shows a sum;
- the outputs hold still when inputs and configuration hold still;
- reset clears everything.

The bench scenarios cover the rest. These are the fuse addressing, the uneven row counts at the boundaries between cells, the placement of the global rows, the mode-bit mapping, and the one-cycle timing. Each of these depends on absolute positions in the map that a local property cannot know.

// File: rtl/pla_pkg.sv
package pla_pkg;

  // Logic rows of cell k: grows by step toward the middle of the array.
  function automatic int terms_of(input int k, input int n_out,
                                  input int pt_min, input int pt_step);
    int d;
    d = (k < n_out - 1 - k) ? k : (n_out - 1 - k);
    return pt_min + pt_step * d;
  endfunction

  // Row index of the enable row of cell k (row 0 is the global reset row).
  function automatic int first_row(input int k, input int n_out,
                                   input int pt_min, input int pt_step);
    int r;
    r = 1;
    for (int j = 0; j < k; j++) r += terms_of(j, n_out, pt_min, pt_step) + 1;
    return r;
  endfunction

  // Total rows: reset row, all cell blocks, preset row.
  function automatic int row_total(input int n_out, input int pt_min,
                                   input int pt_step);
    return first_row(n_out, n_out, pt_min, pt_step) + 1;
  endfunction

endpackage

// File: rtl/pla_term.sv
module pla_term #(
  parameter int IN_W = 22,
  localparam int COLS = 2 * IN_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [COLS-1:0] row,
  input  logic [IN_W-1:0] lits_in,
  output logic            term
);

  logic [COLS-1:0] lit;
  logic [IN_W-1:0] both_conn;

  for (genvar i = 0; i < IN_W; i++) begin : g_lit
    assign lit[2*i]     = lits_in[i];
    assign lit[2*i + 1] = ~lits_in[i];
    assign both_conn[i] = row[2*i] & row[2*i + 1];
  end

  // A disconnected column passes 1; a connected one passes its literal.
  assign term = &(lit | ~row);

  AST_CONFLICT_FALSE: assert property (@(posedge clk) disable iff (rst)
    (|both_conn) |-> !term); // R3

  AST_EMPTY_TRUE: assert property (@(posedge clk) disable iff (rst)
    (row == '0) |-> term); // R4

endmodule

// File: rtl/pla_cell.sv
module pla_cell #(
  parameter int IN_W    = 22,
  parameter int N_TERMS = 8,
  localparam int COLS   = 2 * IN_W,
  localparam int ROWS   = N_TERMS + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ROWS*COLS-1:0] rows,
  input  logic [IN_W-1:0]      lits_in,
  output logic                 sum,
  output logic                 oe
);

  logic [ROWS-1:0] tv;

  for (genvar t = 0; t < ROWS; t++) begin : g_row
    pla_term #(.IN_W(IN_W)) u_term (
      .clk    (clk),
      .rst    (rst),
      .row    (rows[t*COLS +: COLS]),
      .lits_in(lits_in),
      .term   (tv[t])
    );
  end

  // Row 0 is the enable row; rows 1..N_TERMS feed the sum.
  assign oe  = tv[0];
  assign sum = |tv[ROWS-1:1];

  AST_ENABLE_NOT_IN_SUM: assert property (@(posedge clk) disable iff (rst)
    (oe && !(|tv[ROWS-1:1])) |-> !sum); // R5

endmodule

// File: rtl/pla_array.sv
module pla_array #(
  parameter int IN_W    = 22,
  parameter int N_OUT   = 10,
  parameter int PT_MIN  = 8,
  parameter int PT_STEP = 2,
  localparam int COLS      = 2 * IN_W,
  localparam int N_ROWS    = pla_pkg::row_total(N_OUT, PT_MIN, PT_STEP),
  localparam int SP_ROW    = N_ROWS - 1,
  localparam int MODE_BASE = N_ROWS * COLS,
  localparam int FUSE_W    = MODE_BASE + 2 * N_OUT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FUSE_W-1:0]  fuse_map,
  input  logic [IN_W-1:0]    arr_in,
  output logic [N_OUT-1:0]   sum_out,
  output logic [N_OUT-1:0]   oe_out,
  output logic               ar_out,
  output logic               sp_out,
  output logic [2*N_OUT-1:0] mode_out
);

  logic [N_OUT-1:0] sum_c;
  logic [N_OUT-1:0] oe_c;
  logic             ar_c;
  logic             sp_c;

  pla_term #(.IN_W(IN_W)) u_ar (
    .clk(clk), .rst(rst),
    .row(fuse_map[0 +: COLS]),
    .lits_in(arr_in),
    .term(ar_c)
  );

  pla_term #(.IN_W(IN_W)) u_sp (
    .clk(clk), .rst(rst),
    .row(fuse_map[SP_ROW*COLS +: COLS]),
    .lits_in(arr_in),
    .term(sp_c)
  );

  for (genvar k = 0; k < N_OUT; k++) begin : g_cell
    localparam int NT   = pla_pkg::terms_of(k, N_OUT, PT_MIN, PT_STEP);
    localparam int ROW0 = pla_pkg::first_row(k, N_OUT, PT_MIN, PT_STEP);
    pla_cell #(.IN_W(IN_W), .N_TERMS(NT)) u_cell (
      .clk    (clk),
      .rst    (rst),
      .rows   (fuse_map[ROW0*COLS +: (NT+1)*COLS]),
      .lits_in(arr_in),
      .sum    (sum_c[k]),
      .oe     (oe_c[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_out  <= '0;
      oe_out   <= '0;
      ar_out   <= 1'b0;
      sp_out   <= 1'b0;
      mode_out <= '0;
    end else begin
      sum_out  <= sum_c;
      oe_out   <= oe_c;
      ar_out   <= ar_c;
      sp_out   <= sp_c;
      mode_out <= fuse_map[MODE_BASE +: 2*N_OUT];
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (sum_out == '0 && oe_out == '0 && !ar_out && !sp_out && mode_out == '0)); // R1

  AST_HOLD_WHEN_STILL: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(fuse_map) && $stable(arr_in))
      |=> $stable({sum_out, oe_out, ar_out, sp_out, mode_out})); // R2

endmodule

// File: tb/pla_array_test.sv
module pla_array_test;

  localparam int FW = 5828;
  localparam int RW = 44;
  localparam int CNT [10] = '{8, 10, 12, 14, 16, 16, 14, 12, 10, 8};
  localparam logic [19:0] MODE_PAT = 20'h5A3C6;
  localparam int NV = 7;
  // {arr_in[21:0], sp, ar, oe[9:0], sum[9:0]}
  localparam logic [43:0] VEC [NV] = '{
    {22'h000000, 1'b1, 1'b0, 10'h000, 10'h018},
    {22'h000001, 1'b1, 1'b0, 10'h000, 10'h019},
    {22'h000003, 1'b1, 1'b0, 10'h000, 10'h018},
    {22'h200024, 1'b1, 1'b0, 10'h020, 10'h208},
    {22'h001C00, 1'b0, 1'b1, 10'h000, 10'h018},
    {22'h3FFFFF, 1'b0, 1'b1, 10'h020, 10'h208},
    {22'h000400, 1'b1, 1'b0, 10'h000, 10'h018}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [FW-1:0] fuse_map = '1;
  logic [21:0]   arr_in = '0;
  logic [9:0]    sum_out, oe_out;
  logic          ar_out, sp_out;
  logic [19:0]   mode_out;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pla_array uut (
    .clk(clk), .rst(rst), .fuse_map(fuse_map), .arr_in(arr_in),
    .sum_out(sum_out), .oe_out(oe_out), .ar_out(ar_out),
    .sp_out(sp_out), .mode_out(mode_out)
  );

  function automatic int cell_row(input int k);
    int r;
    r = 1;
    for (int j = 0; j < k; j++) r += CNT[j] + 1;
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic blow_row(input int row);
    for (int c = 0; c < RW; c++) fuse_map[row*RW + c] = 1'b0;
  endtask

  task automatic keep(input int row, input int col);
    fuse_map[row*RW + col] = 1'b1;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset state", {sum_out, oe_out, ar_out, sp_out}, 32'h0);
    chk("R1 reset mode", {12'h0, mode_out}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R3 fully intact rows false", {sum_out, oe_out, ar_out, sp_out}, 32'h0);
    chk("R10 all-ones mode", {12'h0, mode_out}, 32'h000FFFFF);

    // Program the map.
    blow_row(cell_row(0) + 1); keep(cell_row(0) + 1, 0); keep(cell_row(0) + 1, 3);
    blow_row(cell_row(9) + 8); keep(cell_row(9) + 8, 42);
    blow_row(cell_row(4) + 16); keep(cell_row(4) + 16, 11);
    blow_row(cell_row(5)); keep(cell_row(5), 4);
    blow_row(cell_row(3) + 1);
    blow_row(0); keep(0, 20); keep(0, 22);
    blow_row(5764 / RW); keep(5764 / RW, 25);
    for (int j = 0; j < 20; j++) fuse_map[5808 + j] = MODE_PAT[j];
    @(negedge clk);
    chk("R10 mode bit placement", {12'h0, mode_out}, {12'h0, MODE_PAT});

    for (int i = 0; i < NV; i++) begin
      arr_in = VEC[i][43:22];
      @(negedge clk);
      chk("R3 R4 R5 R7 sums", {22'h0, sum_out}, {22'h0, VEC[i][9:0]});
      chk("R6 enables", {22'h0, oe_out}, {22'h0, VEC[i][19:10]});
      chk("R8 global reset term", {31'h0, ar_out}, {31'h0, VEC[i][20]});
      chk("R9 global preset term", {31'h0, sp_out}, {31'h0, VEC[i][21]});
    end

    // Latency: new input not visible before the next edge.
    arr_in = 22'h000001;
    #2;
    chk("R2 old value before edge", {22'h0, sum_out}, 32'h018);
    @(negedge clk);
    chk("R2 new value after edge", {22'h0, sum_out}, 32'h019);

    // Mid-run reset.
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-run reset", {sum_out, oe_out, ar_out, sp_out}, 32'h0);
    chk("R1 mid-run reset mode", {12'h0, mode_out}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 R7 recovery", {22'h0, sum_out}, 32'h019);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule